// File: doc/BRIEF.md
# Radio Transceiver Interrupt Mapper

This block collects status information from the digital core of a packet radio and drives two interrupt pins. Each pin has its own source selector. The selector picks one signal from a shared set. Some signals in the set are decoded from the operating state code, including the frequency-synthesizer tuning phases that come before receive and transmit. Some are held event flags that capture strobes from the packet engine and the timers. The rest are status levels from the receive and transmit FIFOs, the RSSI detector and the battery monitor.

A packet-done event collects four ways a receive can end: a good packet, a Manchester decode error, an address (node) mismatch, or a signal collision. The two decode errors also pulse a decoder-reset output for one cycle. A collision instead raises a pending flag. That flag stays set until the host acknowledges it. One polarity input inverts both pins together. Each pin is a register, so the chosen signal shows up on the pin one clock after it is sampled.

Top module: `rf_irq_router`

## Requirements
- R1: The active flags decode `op_state` (0 sleep, 1 standby, 2 tune-for-RX, 3 tune-for-TX, 4 RX, 5 TX). RX-active is 1 in states 2 and 4. TX-active is 1 in states 3 and 5. Any-active is 1 in states 2 through 5. Each flag is 0 in every other state.
- R2: The state flags are exact decodes. Standby is 1 in state 1. Tuning is 1 in state 2 or state 3. In-RX is 1 in state 4. In-TX is 1 in state 5.
- R3: Each event flag is set by a one-cycle strobe. `evt_clr` uses bit 0 preamble, 1 sync, 2 node, 3 CRC, 4 packet-done, 5 sleep timeout, 6 RX timeout, 7 TX done. Once set, the flag stays at 1 until its clear bit is asserted.
- R4: When a clear bit and its event strobe arrive in the same cycle, the clear wins and the flag ends at 0.
- R5: Any one of `ev_pkt_ok`, `ev_manch_err`, `ev_node_err` or `ev_collision` sets the packet-done flag.
- R6: `dec_reset` is high in the cycle after a Manchester or node error strobe and low otherwise. A collision does not pulse `dec_reset`. It sets `coll_pend`, which stays at 1 until `coll_ack` is asserted.
- R7: The RX-FIFO write strobe is passed through as a pulse. A one-cycle strobe gives exactly one cycle of active level on the pin that selects it.
- R8: Level sources are registered once on the way to the pin and are not latched. Select codes: 16 RX not-empty, 17 RX threshold, 18 RX full, 19 RX write pulse, 20 RX overflow, 21 TX not-empty, 22 TX threshold, 23 TX full, 24 RSSI valid, 25 low battery. State flags use codes 1 to 7 in the order of R1 and R2. Event flags use codes 8 to 15 in the bit order of R3.
- R9: When `inv_polarity` is 1, both pins are active low, so the pin carries the inverse of the selected source.
- R10: The two pins select independently from the same source set. When both pins use the same code, they are identical.
- R11: Select code 0 and codes 26 to 31 drive the inactive level.
- R12: While `rst_n` is low, both pins, `dec_reset` and `coll_pend` are 0 and every event flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_state | input | 3 | Operating state code |
| ev_preamble | input | 1 | Preamble detected strobe |
| ev_sync | input | 1 | Sync word detected strobe |
| ev_node | input | 1 | Node address matched strobe |
| ev_crc_ok | input | 1 | CRC good strobe |
| ev_pkt_ok | input | 1 | Packet received correctly strobe |
| ev_manch_err | input | 1 | Manchester decode error strobe |
| ev_node_err | input | 1 | Node address error strobe |
| ev_collision | input | 1 | Signal collision strobe |
| ev_sleep_to | input | 1 | Sleep timer timeout strobe |
| ev_rx_to | input | 1 | RX timer timeout strobe |
| ev_tx_done | input | 1 | Transmission complete strobe |
| coll_ack | input | 1 | Host acknowledge of a collision |
| evt_clr | input | 8 | Per-flag clear (bit order in R3) |
| rx_nempty | input | 1 | RX FIFO not empty |
| rx_thr | input | 1 | RX FIFO above threshold |
| rx_full | input | 1 | RX FIFO full |
| rx_wr | input | 1 | RX FIFO byte-write pulse |
| rx_ovf | input | 1 | RX FIFO overflow |
| tx_nempty | input | 1 | TX FIFO not empty |
| tx_thr | input | 1 | TX FIFO above threshold |
| tx_full | input | 1 | TX FIFO full |
| rssi_valid | input | 1 | RSSI above detect level |
| low_batt | input | 1 | Supply below battery threshold |
| inv_polarity | input | 1 | 1 makes both pins active low |
| sel_a | input | 5 | Source code for pin A |
| sel_b | input | 5 | Source code for pin B |
| irq_a | output | 1 | Interrupt pin A |
| irq_b | output | 1 | Interrupt pin B |
| dec_reset | output | 1 | Decoder reset pulse |
| coll_pend | output | 1 | Collision awaiting host acknowledge |

## Verification
Some rules can be checked on every cycle, and assertions cover these:
- event flags set and hold;
- a clear wins over a simultaneous set;
- the decoder-reset pulse follows exactly the two decode-error strobes;
- a pending collision persists until it is acknowledged;
- unused codes give the inactive level;
- a selected write pulse reaches the pin.

Other behaviour can only be shown by the bench's scenarios. These include the state decodes across the full sequence of states, each of the four packet-done causes in turn, polarity inversion applied to both pins, and the two pins selecting different or equal sources at the same time.

// File: rtl/rf_irq_router.sv
module rf_irq_router #(
  parameter int ST_W = 3,
  parameter logic [2:0] ST_STBY    = 3'd1,
  parameter logic [2:0] ST_TUNE_RX = 3'd2,
  parameter logic [2:0] ST_TUNE_TX = 3'd3,
  parameter logic [2:0] ST_RX      = 3'd4,
  parameter logic [2:0] ST_TX      = 3'd5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] op_state,
  input  logic            ev_preamble,
  input  logic            ev_sync,
  input  logic            ev_node,
  input  logic            ev_crc_ok,
  input  logic            ev_pkt_ok,
  input  logic            ev_manch_err,
  input  logic            ev_node_err,
  input  logic            ev_collision,
  input  logic            ev_sleep_to,
  input  logic            ev_rx_to,
  input  logic            ev_tx_done,
  input  logic            coll_ack,
  input  logic [7:0]      evt_clr,
  input  logic            rx_nempty,
  input  logic            rx_thr,
  input  logic            rx_full,
  input  logic            rx_wr,
  input  logic            rx_ovf,
  input  logic            tx_nempty,
  input  logic            tx_thr,
  input  logic            tx_full,
  input  logic            rssi_valid,
  input  logic            low_batt,
  input  logic            inv_polarity,
  input  logic [4:0]      sel_a,
  input  logic [4:0]      sel_b,
  output logic            irq_a,
  output logic            irq_b,
  output logic            dec_reset,
  output logic            coll_pend
);
  localparam int N_EVT = 8;
  localparam int N_SRC = 32;
  localparam logic [4:0] LAST_CODE = 5'd25;

  logic st_stby, st_tune, st_rx, st_tx, rx_act, tx_act, trx_act;
  assign st_stby = (op_state == ST_STBY);
  assign st_tune = (op_state == ST_TUNE_RX) || (op_state == ST_TUNE_TX);
  assign st_rx   = (op_state == ST_RX);
  assign st_tx   = (op_state == ST_TX);
  assign rx_act  = (op_state == ST_TUNE_RX) || st_rx;
  assign tx_act  = (op_state == ST_TUNE_TX) || st_tx;
  assign trx_act = rx_act || tx_act;

  logic pkt_done_set, dec_err;
  assign dec_err      = ev_manch_err | ev_node_err;
  assign pkt_done_set = ev_pkt_ok | dec_err | ev_collision;

  logic [N_EVT-1:0] evt_set, evt_q;
  assign evt_set = {ev_tx_done, ev_rx_to, ev_sleep_to, pkt_done_set,
                    ev_crc_ok, ev_node, ev_sync, ev_preamble};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q | evt_set) & ~evt_clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dec_reset <= 1'b0;
      coll_pend <= 1'b0;
    end else begin
      dec_reset <= dec_err;
      coll_pend <= (coll_pend | ev_collision) & ~coll_ack;
    end

  logic [N_SRC-1:0] src;
  assign src = {6'b0, low_batt, rssi_valid, tx_full, tx_thr, tx_nempty,
                rx_ovf, rx_wr, rx_full, rx_thr, rx_nempty, evt_q,
                st_tx, st_rx, st_tune, st_stby, trx_act, tx_act, rx_act, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_a <= 1'b0;
      irq_b <= 1'b0;
    end else begin
      irq_a <= src[sel_a] ^ inv_polarity;
      irq_b <= src[sel_b] ^ inv_polarity;
    end

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt_chk
    p_set_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_set[i] || evt_q[i]) && !evt_clr[i]) |=> evt_q[i]);
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_clr[i] |=> !evt_q[i]);
  end

  p_pkt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_pkt_ok || ev_manch_err || ev_node_err || ev_collision) && !evt_clr[4]) |=> evt_q[4]);
  p_dec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_manch_err || ev_node_err) |=> dec_reset);
  p_dec_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_manch_err && !ev_node_err) |=> !dec_reset);
  p_coll_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_pend && !coll_ack) |=> coll_pend);
  p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr && sel_a == 5'd19) |=> (irq_a != $past(inv_polarity)));
  p_unused_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 5'd0 || sel_a > LAST_CODE) |=> (irq_a == $past(inv_polarity)));
  p_unused_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == 5'd0 || sel_b > LAST_CODE) |=> (irq_b == $past(inv_polarity)));
endmodule

// File: tb/test_rf_irq_router.sv
module test_rf_irq_router;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [2:0] op_state;
  logic ev_preamble, ev_sync, ev_node, ev_crc_ok, ev_pkt_ok, ev_manch_err,
        ev_node_err, ev_collision, ev_sleep_to, ev_rx_to, ev_tx_done, coll_ack;
  logic [7:0] evt_clr;
  logic rx_nempty, rx_thr, rx_full, rx_wr, rx_ovf, tx_nempty, tx_thr, tx_full,
        rssi_valid, low_batt, inv_polarity;
  logic [4:0] sel_a, sel_b;
  logic irq_a, irq_b, dec_reset, coll_pend;

  rf_irq_router i_rf_irq_router (.*);

  typedef struct {
    logic [3:0] exp;
    logic [3:0] msk;
    string      tag;
  } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // observed vector: {coll_pend, dec_reset, irq_b, irq_a}
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      item_t it;
      logic [3:0] got;
      it = sb.pop_front();
      got = {coll_pend, dec_reset, irq_b, irq_a};
      n_chk++;
      if ((got & it.msk) !== (it.exp & it.msk)) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b (mask %b)", it.tag, got, it.exp, it.msk);
      end
    end
  end

  task automatic push(input logic [3:0] e, input logic [3:0] m, input string tag);
    item_t it;
    it.exp = e; it.msk = m; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
  endtask

  task automatic drv();
    @(negedge clk);
  endtask

  task automatic pins(input logic a, input logic b, input string tag);
    push({2'b00, b, a}, 4'b0011, tag);
  endtask

  task automatic clear_all();
    drv(); evt_clr = 8'hFF; tick();
    drv(); evt_clr = 8'h00;
  endtask

  task automatic pulse_cause(input int k);
    drv();
    case (k)
      0: ev_pkt_ok = 1;
      1: ev_manch_err = 1;
      2: ev_node_err = 1;
      default: ev_collision = 1;
    endcase
    tick();
    drv(); ev_pkt_ok = 0; ev_manch_err = 0; ev_node_err = 0; ev_collision = 0;
    tick();
    pins(1'b1, 1'b0, $sformatf("R5 cause %0d sets packet-done", k));
    drv(); evt_clr[4] = 1; tick();
    drv(); evt_clr[4] = 0; coll_ack = 1; tick();
    pins(1'b0, 1'b0, $sformatf("R5 cause %0d cleared", k));
    drv(); coll_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_state = 0;
    {ev_preamble, ev_sync, ev_node, ev_crc_ok, ev_pkt_ok, ev_manch_err,
     ev_node_err, ev_collision, ev_sleep_to, ev_rx_to, ev_tx_done, coll_ack} = '0;
    evt_clr = 0;
    {rx_nempty, rx_thr, rx_full, rx_wr, rx_ovf, tx_nempty, tx_thr, tx_full,
     rssi_valid, low_batt, inv_polarity} = '0;
    sel_a = 5'd1; sel_b = 5'd3;
    tick(); tick();
    push(4'b0000, 4'b1111, "R12 reset state");
    drv(); rst_n = 1;

    // R1 active flags
    drv(); sel_a = 5'd1; sel_b = 5'd2; op_state = 3'd2; tick();
    pins(1, 0, "R1 tune-rx: rx-active");
    drv(); op_state = 3'd5; tick();
    pins(0, 1, "R1 tx: tx-active");
    drv(); sel_a = 5'd3; op_state = 3'd1; tick();
    pins(0, 0, "R1 standby: none active");
    drv(); op_state = 3'd3; tick();
    pins(1, 1, "R1 tune-tx: any-active and tx-active");
    drv(); op_state = 3'd0; tick();
    pins(0, 0, "R1 sleep: none active");

    // R2 state decode
    drv(); sel_a = 5'd4; sel_b = 5'd5; op_state = 3'd1; tick();
    pins(1, 0, "R2 standby flag");
    drv(); op_state = 3'd3; tick();
    pins(0, 1, "R2 tuning flag");
    drv(); sel_a = 5'd6; sel_b = 5'd7; op_state = 3'd4; tick();
    pins(1, 0, "R2 in-rx flag");
    drv(); op_state = 3'd5; tick();
    pins(0, 1, "R2 in-tx flag");
    drv(); op_state = 3'd0;

    // R3 latch and hold
    drv(); sel_a = 5'd9; sel_b = 5'd8; ev_sync = 1; tick();
    drv(); ev_sync = 0; tick();
    pins(1, 0, "R3 sync flag set");
    tick(); tick(); tick();
    pins(1, 0, "R3 sync flag held");
    drv(); sel_a = 5'd15; sel_b = 5'd13; ev_tx_done = 1; ev_sleep_to = 1; tick();
    drv(); ev_tx_done = 0; ev_sleep_to = 0; tick();
    pins(1, 1, "R3 tx-done and sleep flags set");
    clear_all();

    // R4 clear wins
    drv(); sel_a = 5'd9; ev_sync = 1; evt_clr[1] = 1; tick();
    drv(); ev_sync = 0; evt_clr[1] = 0; tick();
    pins(0, 0, "R4 clear beats set");

    // R5 packet-done causes
    drv(); sel_a = 5'd12; sel_b = 5'd0;
    for (int k = 0; k < 4; k++) pulse_cause(k);

    // R6 decoder reset and collision pending
    drv(); ev_manch_err = 1; tick();
    push(4'b0100, 4'b1100, "R6 dec_reset after manchester error");
    drv(); ev_manch_err = 0; ev_node_err = 1; tick();
    push(4'b0100, 4'b1100, "R6 dec_reset after node error");
    drv(); ev_node_err = 0; ev_collision = 1; tick();
    push(4'b1000, 4'b1100, "R6 collision: pending, no dec_reset");
    drv(); ev_collision = 0; tick(); tick(); tick();
    push(4'b1000, 4'b1100, "R6 collision stays pending");
    drv(); coll_ack = 1; tick();
    push(4'b0000, 4'b1100, "R6 ack clears pending");
    drv(); coll_ack = 0;
    clear_all();

    // R7 write pulse
    drv(); sel_a = 5'd19; rx_wr = 1; tick();
    pins(1, 0, "R7 write pulse reaches pin");
    drv(); rx_wr = 0; tick();
    pins(0, 0, "R7 pulse lasts one cycle");

    // R8 levels
    drv(); sel_a = 5'd23; sel_b = 5'd25; tx_full = 1; tick();
    pins(1, 0, "R8 tx full level");
    drv(); low_batt = 1; tick();
    pins(1, 1, "R8 low battery level");
    drv(); tx_full = 0; tick();
    pins(0, 1, "R8 level not latched");

    // R9 polarity
    drv(); inv_polarity = 1; sel_a = 5'd0; tick();
    pins(1, 0, "R9 inverted: inactive high, active low");

    // R11 unused codes
    drv(); inv_polarity = 0; sel_a = 5'd26; sel_b = 5'd31;
    rx_nempty = 1; rx_thr = 1; rx_full = 1; rx_ovf = 1; tx_nempty = 1;
    tx_thr = 1; tx_full = 1; rssi_valid = 1; op_state = 3'd4; tick();
    pins(0, 0, "R11 unused codes inactive");
    drv(); inv_polarity = 1; tick();
    pins(1, 1, "R11 unused codes inactive under inversion");

    // R10 independent pins
    drv(); inv_polarity = 0; sel_a = 5'd16; sel_b = 5'd16; tick();
    pins(1, 1, "R10 same code, same pin value");
    drv(); rx_nempty = 0; sel_b = 5'd24; tick();
    pins(0, 1, "R10 pins select independently");

    drv(); drv();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule